// File: doc/BRIEF.md
# 8-bit Shift and Rotate Unit

A purely combinational datapath slice for an 8-bit processor core. Given a 3-bit operation code, an 8-bit operand and the current flag byte, it returns the shifted or rotated byte and the flag byte that the core writes back in the same cycle. The decoder, register file and memory path sit around it and are not part of this block.

There are two families of operation, and they treat flags differently. The three shifts are logical right, arithmetic left and arithmetic right. They rebuild the whole flag byte from the result. The four accumulator rotates are circular left, circular right, left through carry and right through carry. They keep sign, zero, parity and the two spare flag bits, clear half-carry and subtract, and load carry with the bit that leaves the byte. Code 7 has no operation and passes the operand and the flags through unchanged.

The flag byte holds carry in bit 0, subtract in bit 1, parity in bit 2, half-carry in bit 4, zero in bit 6 and sign in bit 7. Bits 3 and 5 are spare.

Top module: `sr_unit8`

## Requirements
- R1: With op_sel = 0 (logical right shift), the result is the operand shifted right by one with 0 entering bit 7, and carry (flag bit 0) takes the operand's old bit 0.
- R2: With op_sel = 1 (arithmetic left shift), the result is the operand shifted left by one with 0 entering bit 0, and carry (flag bit 0) takes the operand's old bit 7.
- R3: With op_sel = 2 (arithmetic right shift), the result is the operand shifted right by one with bit 7 kept, and carry (flag bit 0) takes the operand's old bit 0.
- R4: For op_sel 0, 1 and 2, the output flags are rebuilt from the result alone: sign (bit 7) equals result bit 7, zero (bit 6) is set when the result is 0, and parity (bit 2) is set when the result has an even number of ones. Half-carry (bit 4), subtract (bit 1) and the spare bits 5 and 3 are 0.
- R5: For op_sel 3 to 6, output flag bits 7, 6, 5, 3 and 2 equal the input flag bits, bits 4 and 1 are 0, and bit 0 holds the bit rotated out of the operand.
- R6: op_sel = 3 rotates left with old bit 7 entering bit 0. op_sel = 4 rotates right with old bit 0 entering bit 7.
- R7: op_sel = 5 rotates left with the incoming carry (flag bit 0) entering bit 0. op_sel = 6 rotates right with the incoming carry entering bit 7.
- R8: op_sel = 7 returns the operand as the result and the input flags as the output flags, unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_sel | input | 3 | Operation code (0 to 6 as in the requirements, 7 means pass through) |
| opnd | input | 8 | Operand byte |
| flg_in | input | 8 | Current flag byte |
| res | output | 8 | Shifted or rotated byte |
| flg_out | output | 8 | Updated flag byte |

## Verification
The block holds no state, so an error is visible at the ports in the same cycle as the inputs that expose it. A wrong bit select shows up as a result or carry error on the first operand whose edge bit differs from its neighbour. A wrong mask shows up as a leaked or lost flag bit whenever the incoming flags are all ones. For these reasons every code is driven with all 256 operands under both incoming carry values, and the flag inputs are alternated so that the kept bits and the cleared bits are both seen.

// File: rtl/sr_unit8.sv
`timescale 1ns/1ps
module sr_unit8 (
  input  logic [2:0] op_sel,
  input  logic [7:0] opnd,
  input  logic [7:0] flg_in,
  output logic [7:0] res,
  output logic [7:0] flg_out
);
  localparam logic [2:0] OP_LSR = 3'd0, OP_ASL = 3'd1, OP_ASR = 3'd2,
                         OP_RLC = 3'd3, OP_RRC = 3'd4, OP_RLT = 3'd5,
                         OP_RRT = 3'd6;
  localparam logic [7:0] KEEP_MASK = 8'hEC;

  logic [7:0] r;
  logic       cout;
  logic       is_shift, is_rot;

  always_comb begin
    r = opnd;
    cout = flg_in[0];
    unique case (op_sel)
      OP_LSR: begin r = {1'b0, opnd[7:1]};      cout = opnd[0]; end
      OP_ASL: begin r = {opnd[6:0], 1'b0};      cout = opnd[7]; end
      OP_ASR: begin r = {opnd[7], opnd[7:1]};   cout = opnd[0]; end
      OP_RLC: begin r = {opnd[6:0], opnd[7]};   cout = opnd[7]; end
      OP_RRC: begin r = {opnd[0], opnd[7:1]};   cout = opnd[0]; end
      OP_RLT: begin r = {opnd[6:0], flg_in[0]}; cout = opnd[7]; end
      OP_RRT: begin r = {flg_in[0], opnd[7:1]}; cout = opnd[0]; end
      default: begin r = opnd; cout = flg_in[0]; end
    endcase
  end

  assign is_shift = (op_sel <= OP_ASR);
  assign is_rot   = (op_sel >= OP_RLC) && (op_sel <= OP_RRT);

  assign res = r;
  assign flg_out = is_shift ? {r[7], (r == 8'h00), 3'b000, ~^r, 1'b0, cout} :
                   is_rot   ? ((flg_in & KEEP_MASK) | {7'd0, cout}) :
                              flg_in;
endmodule

// File: rtl/sr_unit8_chk.sv
`timescale 1ns/1ps
module sr_unit8_chk (
  input logic [2:0] op_sel,
  input logic [7:0] opnd,
  input logic [7:0] flg_in,
  input logic [7:0] res,
  input logic [7:0] flg_out
);
  always_comb begin
    if (op_sel == 3'd0) begin
      p_lsr_r1: assert (res[6:0] == opnd[7:1] && !res[7] && flg_out[0] == opnd[0]) else $error("p_lsr_r1");
    end
    if (op_sel == 3'd1) begin
      p_asl_r2: assert (res[7:1] == opnd[6:0] && !res[0] && flg_out[0] == opnd[7]) else $error("p_asl_r2");
    end
    if (op_sel == 3'd2) begin
      p_asr_r3: assert (res[6:0] == opnd[7:1] && res[7] == opnd[7] && flg_out[0] == opnd[0]) else $error("p_asr_r3");
    end
    if (op_sel <= 3'd2) begin
      p_shflags_r4: assert (flg_out[7] == res[7] && flg_out[6] == (res == 8'h00) &&
                            flg_out[2] == ($countones(res) % 2 == 0) &&
                            flg_out[5:3] == 3'b000 && !flg_out[1]) else $error("p_shflags_r4");
    end
    if (op_sel >= 3'd3 && op_sel <= 3'd6) begin
      p_rotkeep_r5: assert (flg_out[7:5] == flg_in[7:5] && flg_out[3:2] == flg_in[3:2] &&
                            !flg_out[4] && !flg_out[1]) else $error("p_rotkeep_r5");
      p_rotbits_r5: assert ($countones(res) + flg_out[0] == $countones(opnd) + flg_in[0] ||
                            op_sel == 3'd3 || op_sel == 3'd4) else $error("p_rotbits_r5");
    end
    if (op_sel == 3'd3 || op_sel == 3'd4) begin
      p_circ_r6: assert ($countones(res) == $countones(opnd)) else $error("p_circ_r6");
    end
    if (op_sel == 3'd5) begin
      p_rlt_r7: assert (res[0] == flg_in[0] && flg_out[0] == opnd[7]) else $error("p_rlt_r7");
    end
    if (op_sel == 3'd6) begin
      p_rrt_r7: assert (res[7] == flg_in[0] && flg_out[0] == opnd[0]) else $error("p_rrt_r7");
    end
    if (op_sel == 3'd7) begin
      p_pass_r8: assert (res == opnd && flg_out == flg_in) else $error("p_pass_r8");
    end
  end
endmodule

bind sr_unit8 sr_unit8_chk u_chk (.op_sel(op_sel), .opnd(opnd), .flg_in(flg_in), .res(res), .flg_out(flg_out));

// File: tb/sim_sr_unit8.sv
`timescale 1ns/1ps
module sim_sr_unit8;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  logic [2:0] op_sel;
  logic [7:0] opnd, flg_in, res, flg_out;
  int checks = 0, fails = 0;
  bit done = 0;

  sr_unit8 u0 (.op_sel(op_sel), .opnd(opnd), .flg_in(flg_in), .res(res), .flg_out(flg_out));

  // {op, operand, flags in, expected result, expected flags}
  localparam int NV = 14;
  localparam logic [34:0] VEC [NV] = '{
    {3'd0, 8'h01, 8'h00, 8'h00, 8'h45},
    {3'd0, 8'h80, 8'hFF, 8'h40, 8'h00},
    {3'd1, 8'h80, 8'h00, 8'h00, 8'h45},
    {3'd1, 8'h41, 8'h00, 8'h82, 8'h84},
    {3'd2, 8'h81, 8'h00, 8'hC0, 8'h85},
    {3'd2, 8'h7E, 8'hFF, 8'h3F, 8'h04},
    {3'd3, 8'h80, 8'hFF, 8'h01, 8'hED},
    {3'd3, 8'h01, 8'h00, 8'h02, 8'h00},
    {3'd4, 8'h01, 8'h13, 8'h80, 8'h01},
    {3'd5, 8'h80, 8'h01, 8'h01, 8'h01},
    {3'd5, 8'h00, 8'h01, 8'h01, 8'h00},
    {3'd6, 8'h01, 8'h00, 8'h00, 8'h01},
    {3'd6, 8'h00, 8'h01, 8'h80, 8'h00},
    {3'd7, 8'h5A, 8'h3C, 8'h5A, 8'h3C}
  };

  function automatic string tag(input logic [2:0] op);
    case (op)
      3'd0: return "R1/R4";
      3'd1: return "R2/R4";
      3'd2: return "R3/R4";
      3'd3, 3'd4: return "R5/R6";
      3'd5, 3'd6: return "R5/R7";
      default: return "R8";
    endcase
  endfunction

  function automatic logic [15:0] model(input logic [2:0] op, input logic [7:0] a, input logic [7:0] f);
    logic [7:0] r, fo;
    logic c;
    int ones;
    r = a; c = f[0];
    case (op)
      3'd0: begin r = a >> 1; c = a[0]; end
      3'd1: begin r = a << 1; c = a[7]; end
      3'd2: begin r = (a >> 1) | (a & 8'h80); c = a[0]; end
      3'd3: begin r = (a << 1) | (a >> 7); c = a[7]; end
      3'd4: begin r = (a >> 1) | (a << 7); c = a[0]; end
      3'd5: begin r = (a << 1) | {7'd0, f[0]}; c = a[7]; end
      3'd6: begin r = (a >> 1) | {f[0], 7'd0}; c = a[0]; end
      default: ;
    endcase
    if (op <= 3'd2) begin
      ones = 0;
      for (int b = 0; b < 8; b++) ones += r[b];
      fo = 8'h00;
      if (r[7]) fo = fo | 8'h80;
      if (r == 0) fo = fo | 8'h40;
      if (ones % 2 == 0) fo = fo | 8'h04;
      fo = fo | {7'd0, c};
    end else if (op <= 3'd6) begin
      fo = (f & 8'hEC) | {7'd0, c};
    end else begin
      fo = f;
    end
    return {r, fo};
  endfunction

  task automatic apply_check(input logic [2:0] op, input logic [7:0] a, input logic [7:0] f,
                             input logic [7:0] er, input logic [7:0] ef, input string t);
    @(negedge clk);
    op_sel = op; opnd = a; flg_in = f;
    #5;
    checks++;
    if (res !== er || flg_out !== ef) begin
      fails++;
      $display("FAIL %s op=%0d a=%h f=%h: actual res=%h flg=%h expected res=%h flg=%h",
               t, op, a, f, res, flg_out, er, ef);
    end
  endtask

  initial begin
    op_sel = 3'd7; opnd = 8'h00; flg_in = 8'h00;
    repeat (2) @(posedge clk);
    rst = 1'b0;
    // reset / idle state: pass-through code with zero inputs (R8)
    apply_check(3'd7, 8'h00, 8'h00, 8'h00, 8'h00, "R8 idle");
    for (int i = 0; i < NV; i++)
      apply_check(VEC[i][34:32], VEC[i][31:24], VEC[i][23:16], VEC[i][15:8], VEC[i][7:0],
                  tag(VEC[i][34:32]));
    // exhaustive sweep: every op, every operand, both carries, mixed other flags
    for (int op = 0; op < 8; op++)
      for (int a = 0; a < 256; a++)
        for (int c = 0; c < 2; c++) begin
          logic [7:0] f;
          logic [15:0] e;
          f = ((a % 3) == 0) ? {7'h7F, c[0]} : {7'h00, c[0]};
          e = model(op[2:0], a[7:0], f);
          apply_check(op[2:0], a[7:0], f, e[15:8], e[7:0], tag(op[2:0]));
        end
    // corner: R5 kept bits with all-ones flags on a zero operand, RR through carry clear
    apply_check(3'd6, 8'h00, 8'hFE, 8'h00, 8'hEC, "R5/R7");
    // corner: R4 spare bits cleared even when set on input
    apply_check(3'd0, 8'hFF, 8'h28, 8'h7F, 8'h01, "R1/R4");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule